// File: doc/BRIEF.md
# Circuit Path Reservation Controller

This block sits at the source side of a network that moves bulk data over a switched path and carries only short control messages over a narrow electronic channel. The local core hands it a transfer request made of a destination identifier and a payload length. The controller sends a path reservation message toward the destination. It then waits for a reply that either grants the path or reports that the path is blocked.

When the path is granted, the controller raises a transmit-enable strobe for the bulk data sender for exactly the requested number of cycles. It then sends a release message that frees the path. When the path is blocked, the controller waits a pseudo-random backoff interval and tries again. The range of that interval doubles with each consecutive blocked reply, up to a fixed cap, and returns to its smallest value once a transfer completes.

Top module: `path_setup_ctrl`

## Requirements
- R1: After reset, whether asserted at start-up or in the middle of a transfer, the controller is idle: `busy_o`=0, `ctl_tx_valid_o`=0, `tx_en_o`=0, `done_o`=0 and `req_ready_o`=1.
- R2: A request is taken only on a cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only while idle, so a request offered while busy has no effect on the destination that is used.
- R3: After a request is accepted, a control message with type 0 (reservation) and the requested destination is offered on the next cycle. Type, destination and valid stay unchanged until `ctl_tx_ready_i` is seen high.
- R4: A reply is taken only while the controller is waiting for one and only when `ctl_rx_dst_i` equals the current destination. Type 1 means granted and type 2 means blocked. Any other type, or a mismatched destination, is ignored.
- R5: `tx_en_o` rises in the cycle after a granted reply is taken and stays high for exactly the requested length in cycles. A length of 0 produces no `tx_en_o` cycle.
- R6: In the cycle after the transmit window ends (or, for length 0, the cycle after the grant), a control message with type 3 (release) and the same destination is offered. It is held until accepted.
- R7: After the k-th consecutive blocked reply, the controller waits between 1 and 2^min(k,9) cycles and then offers the reservation message again.
- R8: A completed transfer resets the backoff range, so the first blocked reply of the next transfer waits at most 2 cycles.
- R9: `busy_o` is high from the cycle after acceptance up to and including the cycle in which the release message is accepted. `done_o` is high for exactly one cycle, the cycle after that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request offered |
| req_dst_i | input | 8 | Destination of the request |
| req_len_i | input | 16 | Payload length in cycles |
| req_ready_o | output | 1 | Request can be taken (idle) |
| ctl_tx_valid_o | output | 1 | Outgoing control message valid |
| ctl_tx_type_o | output | 2 | Outgoing message type (0 reserve, 3 release) |
| ctl_tx_dst_o | output | 8 | Outgoing message destination |
| ctl_tx_ready_i | input | 1 | Control channel accepts message |
| ctl_rx_valid_i | input | 1 | Incoming reply valid |
| ctl_rx_type_i | input | 2 | Incoming reply type (1 granted, 2 blocked) |
| ctl_rx_dst_i | input | 8 | Destination the reply refers to |
| tx_en_o | output | 1 | Bulk data transmitter enable |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after release is sent |

## Verification
The bench targets off-by-one errors in the transmit window, including a length of 1 and a length of 0. A design that got this wrong would hold `tx_en_o` one cycle too long or too short, or would skip the release message. It feeds replies with a wrong destination or an unexpected type just before the real grant; a design that took them would start transmitting early. It sends long runs of blocked replies and measures every wait against the growing bound. It also checks that the first wait after a successful transfer is back to at most 2 cycles, which catches a backoff exponent that never clears. It offers requests while the controller is busy and checks that a later message never carries that destination. It resets the controller in the middle of a transmit window and checks that the enable drops at once.

// File: rtl/path_setup_pkg.sv
package path_setup_pkg;
  typedef enum logic [1:0] {
    MSG_SETUP    = 2'd0,
    MSG_ACK      = 2'd1,
    MSG_BLOCKED  = 2'd2,
    MSG_TEARDOWN = 2'd3
  } msg_type_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_XFER,
    ST_BACKOFF,
    ST_TEARDOWN
  } state_e;
endpackage

// File: rtl/backoff_gen.sv
module backoff_gen #(
  parameter int unsigned           LFSR_W  = 16,
  parameter int unsigned           MAX_EXP = 8,
  parameter logic [LFSR_W-1:0]     TAPS    = 16'hB400,
  parameter logic [LFSR_W-1:0]     SEED    = 16'hACE1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clr_exp_i,
  output logic done_o
);
  localparam int unsigned CNT_W = MAX_EXP + 2;
  localparam int unsigned EXP_W = $clog2(MAX_EXP + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << (MAX_EXP + 1);

  logic [LFSR_W-1:0] lfsr_q;
  logic [EXP_W-1:0]  exp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
  end

  assign mask = (CNT_W'(2) << exp_q) - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             exp_q <= '0;
    else if (clr_exp_i)                      exp_q <= '0;
    else if (start_i && exp_q != EXP_W'(MAX_EXP)) exp_q <= exp_q + EXP_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= (lfsr_q[CNT_W-1:0] & mask) + CNT_W'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == CNT_W'(1));

  AST_BACKOFF_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R7
  AST_EXP_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q <= EXP_W'(MAX_EXP)); // R7
  AST_BACKOFF_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q != '0); // R7
  AST_EXP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_exp_i && !start_i |=> exp_q == '0); // R8
endmodule

// File: rtl/len_counter.sv
module len_counter #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             en_i,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= len_i;
    else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - LEN_W'(1);
  end

  assign last_o = (cnt_q == LEN_W'(1));

  AST_LEN_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) && !load_i |=> cnt_q == '0); // R5
endmodule

// File: rtl/path_setup_ctrl.sv
module path_setup_ctrl
  import path_setup_pkg::*;
#(
  parameter int unsigned DST_W   = 8,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned LFSR_W  = 16,
  parameter int unsigned MAX_EXP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [DST_W-1:0] req_dst_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             req_ready_o,
  output logic             ctl_tx_valid_o,
  output logic [1:0]       ctl_tx_type_o,
  output logic [DST_W-1:0] ctl_tx_dst_o,
  input  logic             ctl_tx_ready_i,
  input  logic             ctl_rx_valid_i,
  input  logic [1:0]       ctl_rx_type_i,
  input  logic [DST_W-1:0] ctl_rx_dst_i,
  output logic             tx_en_o,
  output logic             busy_o,
  output logic             done_o
);
  state_e           state_q, state_d;
  logic [DST_W-1:0] dst_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q;
  logic             reply_hit, got_ack, got_blk;
  logic             bo_start, bo_clr, bo_done;
  logic             cnt_load, cnt_last;
  logic             td_sent;

  assign reply_hit = (state_q == ST_WAIT) && ctl_rx_valid_i && (ctl_rx_dst_i == dst_q);
  assign got_ack   = reply_hit && (ctl_rx_type_i == 2'(MSG_ACK));
  assign got_blk   = reply_hit && (ctl_rx_type_i == 2'(MSG_BLOCKED));
  assign td_sent   = (state_q == ST_TEARDOWN) && ctl_tx_ready_i;
  assign bo_start  = got_blk;
  assign bo_clr    = td_sent;
  assign cnt_load  = got_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = ST_SETUP;
      ST_SETUP:    if (ctl_tx_ready_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (got_ack)      state_d = (len_q == '0) ? ST_TEARDOWN : ST_XFER;
        else if (got_blk) state_d = ST_BACKOFF;
      end
      ST_XFER:     if (cnt_last) state_d = ST_TEARDOWN;
      ST_BACKOFF:  if (bo_done) state_d = ST_SETUP;
      ST_TEARDOWN: if (ctl_tx_ready_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dst_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= td_sent;
      if (state_q == ST_IDLE && req_valid_i) begin
        dst_q <= req_dst_i;
        len_q <= req_len_i;
      end
    end
  end

  backoff_gen #(
    .LFSR_W  (LFSR_W),
    .MAX_EXP (MAX_EXP)
  ) u_backoff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (bo_start),
    .clr_exp_i (bo_clr),
    .done_o    (bo_done)
  );

  len_counter #(
    .LEN_W (LEN_W)
  ) u_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .len_i  (len_q),
    .en_i   (tx_en_o),
    .last_o (cnt_last)
  );

  assign req_ready_o    = (state_q == ST_IDLE);
  assign busy_o         = (state_q != ST_IDLE);
  assign ctl_tx_valid_o = (state_q == ST_SETUP) || (state_q == ST_TEARDOWN);
  assign ctl_tx_type_o  = (state_q == ST_TEARDOWN) ? 2'(MSG_TEARDOWN) : 2'(MSG_SETUP);
  assign ctl_tx_dst_o   = dst_q;
  assign tx_en_o        = (state_q == ST_XFER);
  assign done_o         = done_q;

  AST_READY_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o); // R2
  AST_MSG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_tx_valid_o && !ctl_tx_ready_i |=>
      ctl_tx_valid_o && $stable(ctl_tx_type_o) && $stable(ctl_tx_dst_o)); // R3
  AST_TXEN_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(ctl_rx_valid_i) && ($past(ctl_rx_type_i) == 2'(MSG_ACK))); // R5
  AST_TD_FOLLOWS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_en_o) |-> ctl_tx_valid_o && (ctl_tx_type_o == 2'(MSG_TEARDOWN))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
endmodule

// File: tb/path_setup_ctrl_bench.sv
module path_setup_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_dst = '0;
  logic [15:0] req_len = '0;
  logic        req_ready;
  logic        tx_valid;
  logic [1:0]  tx_type;
  logic [7:0]  tx_dst;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [1:0]  rx_type = '0;
  logic [7:0]  rx_dst = '0;
  logic        tx_en, busy, done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  path_setup_ctrl u_path_setup_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_dst_i(req_dst), .req_len_i(req_len), .req_ready_o(req_ready),
    .ctl_tx_valid_o(tx_valid), .ctl_tx_type_o(tx_type), .ctl_tx_dst_o(tx_dst), .ctl_tx_ready_i(tx_ready),
    .ctl_rx_valid_i(rx_valid), .ctl_rx_type_i(rx_type), .ctl_rx_dst_i(rx_dst),
    .tx_en_o(tx_en), .busy_o(busy), .done_o(done)
  );

  localparam int NV = 6;
  localparam int VDST [NV] = '{8'h12, 8'hA7, 8'h3C, 8'hFF, 8'h00, 8'h55};
  localparam int VLEN [NV] = '{5,     1,     0,     17,    2,     3};
  localparam int VBLK [NV] = '{0,     1,     0,     3,     10,    1};
  localparam int VDLY [NV] = '{0,     2,     1,     0,     0,     3};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait for a message, hold ready low dly cycles, then accept it
  task automatic take_msg(input int typ, input int dst, input int dly, input string req);
    int n = 0;
    while (!tx_valid && n < 2000) begin @(negedge clk); n++; end
    chk(tx_valid, req, int'(tx_valid), 1);
    chk(int'(tx_type) == typ, req, int'(tx_type), typ);
    chk(int'(tx_dst) == dst, req, int'(tx_dst), dst);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(tx_valid && int'(tx_type) == typ && int'(tx_dst) == dst, "R3 hold", int'(tx_type), typ);
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic reply(input int typ, input int dst);
    rx_valid = 1'b1; rx_type = 2'(typ); rx_dst = 8'(dst);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic run_xfer(input int dst, input int len, input int nblk, input int dly);
    int n;
    chk(req_ready, "R2 ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_dst = 8'(dst); req_len = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R9 busy after accept", int'(busy), 1);
    chk(tx_valid && tx_type == 2'd0, "R3 setup next cycle", int'(tx_valid), 1);
    for (int k = 1; k <= nblk; k++) begin
      take_msg(0, dst, dly, "R3 setup");
      req_valid = 1'b1; req_dst = 8'(dst ^ 8'h5A);
      chk(!req_ready, "R2 busy ignores req", int'(req_ready), 0);
      reply(2, dst);
      req_valid = 1'b0;
      n = 0;
      while (!tx_valid && n < 2000) begin n++; @(negedge clk); end
      chk(n >= 1 && n <= (1 << ((k < 9) ? k : 9)), "R7 backoff bound", n, 1 << ((k < 9) ? k : 9));
    end
    take_msg(0, dst, dly, "R3 setup");
    reply(1, dst ^ 8'h01);
    chk(!tx_en && !tx_valid && busy, "R4 wrong dst ignored", int'(tx_en), 0);
    reply(3, dst);
    chk(!tx_en && !tx_valid && busy, "R4 other type ignored", int'(tx_en), 0);
    reply(1, dst);
    n = 0;
    while (tx_en && n < 70000) begin n++; @(negedge clk); end
    chk(n == len, "R5 tx window", n, len);
    chk(tx_valid && tx_type == 2'd3 && int'(tx_dst) == dst, "R6 release msg", int'(tx_type), 3);
    take_msg(3, dst, dly, "R6 release");
    chk(!busy && done && req_ready, "R9 done after release", int'(done), 1);
    @(negedge clk);
    chk(!done, "R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !tx_en && !done && req_ready, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) run_xfer(VDST[v], VLEN[v], VBLK[v], VDLY[v]);

    // R8: first block after a success waits at most 2 cycles
    req_valid = 1'b1; req_dst = 8'h77; req_len = 16'd1;
    @(negedge clk);
    req_valid = 1'b0;
    take_msg(0, 8'h77, 0, "R3 setup");
    reply(2, 8'h77);
    n = 0;
    while (!tx_valid && n < 2000) begin n++; @(negedge clk); end
    chk(n >= 1 && n <= 2, "R8 exponent cleared", n, 2);
    take_msg(0, 8'h77, 0, "R3 setup");
    reply(1, 8'h77);
    take_msg(3, 8'h77, 0, "R6 release");

    // R1: reset in the middle of a transmit window
    req_valid = 1'b1; req_dst = 8'h21; req_len = 16'd50;
    @(negedge clk);
    req_valid = 1'b0;
    take_msg(0, 8'h21, 0, "R3 setup");
    reply(1, 8'h21);
    repeat (3) @(negedge clk);
    chk(tx_en, "R5 tx active", int'(tx_en), 1);
    rst_n = 1'b0;
    #1;
    chk(!tx_en && !busy && !tx_valid && req_ready, "R1 mid-transfer reset", int'(tx_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_xfer(8'h42, 4, 2, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule